// File: doc/BRIEF.md
# Chip-Select Addressed Seven-Segment Write Port

This block stores segment patterns for four seven-segment digits. A bus master writes to it as four write-only locations. Each write carries a 4-bit value and a 2-bit digit address. It is qualified by two active-low selects: typically an address decoder drives one and the write strobe drives the other.

While both selects are low, the value and the address are sampled into input registers. When either select rises and the window closes, a single commit pulse fires. That pulse decodes the captured value through one of two glyph tables and stores the 7-bit pattern in the addressed digit register. The other three digit registers keep their contents.

The selects are brought into the system clock domain through a short synchronizer. The font input picks the glyph table: a hexadecimal set, or a numeric set with a few letters and a blank. The 28 segment outputs come straight from the digit registers.

Top module: `segdisp_write_port`

## Requirements
- R1: After reset all 28 segment outputs are 0 (all digits blank) and no write is pending.
- R2: Value and address are taken from the last clock cycle in which both synchronized selects were low. Inputs that change two or more cycles after a select has risen do not alter the stored result.
- R3: Address k (00 to 11) writes digit k, which drives segs_out[7k+6:7k]. The other digits keep their patterns.
- R4: Each window in which both selects are low produces exactly one write. This holds whether select A rises first, select B rises first, or both rise together.
- R5: Activity while only one select is low writes nothing.
- R6: With font_code_b = 0, values 0 to 15 show the hex glyphs. Segment bit 0 is a and bit 6 is g. The codes are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R7: With font_code_b = 1, values 0 to 9 match the hex set. Value 10 gives a dash (40), 11 gives E (79), 12 gives H (76), 13 gives L (38), 14 gives P (73) and 15 gives blank (00).
- R8: The font is applied at the moment of the write. A later change of font_code_b does not alter stored digits.
- R9: The new pattern appears on segs_out four clock edges after the select rises. This assumes the select was set up before the first of those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 4 | Value to display |
| addr_in | input | 2 | Digit address |
| sel_a_n | input | 1 | Active-low select A |
| sel_b_n | input | 1 | Active-low select B |
| font_code_b | input | 1 | 0 = hex glyphs, 1 = numeric/letter glyphs |
| segs_out | output | 28 | Four 7-bit digit patterns, digit 0 in the low bits |

## Verification
The assertions check three things on every cycle. A commit pulse never lasts two cycles. The captured value and address stay frozen while the window is closed. A digit register changes only when the write strobe selects it.

Some properties can only be shown by the bench's scenarios. These are the exact glyph values of both fonts, the mapping of addresses to output bit positions, and the four-edge latency. They also include correct writes under the three select release orders, the ignored single-select activity, and the insensitivity to font changes after a write.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
    localparam int SEG_W = 7;
    typedef logic [SEG_W-1:0] glyph_t;

    function automatic glyph_t glyph_of(input logic [3:0] val, input logic code_b);
        glyph_t g;
        case (val)
            4'd0:  g = 7'h3F;
            4'd1:  g = 7'h06;
            4'd2:  g = 7'h5B;
            4'd3:  g = 7'h4F;
            4'd4:  g = 7'h66;
            4'd5:  g = 7'h6D;
            4'd6:  g = 7'h7D;
            4'd7:  g = 7'h07;
            4'd8:  g = 7'h7F;
            4'd9:  g = 7'h6F;
            4'd10: g = code_b ? 7'h40 : 7'h77;
            4'd11: g = code_b ? 7'h79 : 7'h7C;
            4'd12: g = code_b ? 7'h76 : 7'h39;
            4'd13: g = code_b ? 7'h38 : 7'h5E;
            4'd14: g = code_b ? 7'h73 : 7'h79;
            default: g = code_b ? 7'h00 : 7'h71;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/segdisp_sel_sync.sv
module segdisp_sel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], raw_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/segdisp_bank.sv
module segdisp_bank #(
    parameter int DIGITS = 4,
    parameter int SEG_W  = 7,
    localparam int AW    = $clog2(DIGITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [SEG_W-1:0]        wr_glyph,
    output logic [DIGITS*SEG_W-1:0] segs_flat
);
    typedef struct packed {
        logic [DIGITS-1:0][SEG_W-1:0] digit;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [DIGITS-1:0] wr_sel;

    always_comb begin
        for (int i = 0; i < DIGITS; i++)
            wr_sel[i] = wr_en && (wr_addr == AW'(i));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < DIGITS; i++)
            if (wr_sel[i]) bank_d.digit[i] = wr_glyph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign segs_flat = bank_q.digit;

    // R3: at most one digit strobed per cycle
    a_r3_one_digit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_hold
        // R3: a digit not strobed keeps its pattern
        a_r3_hold_digit: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_sel[gi] |=> $stable(bank_q.digit[gi]));
    end
endmodule

// File: rtl/segdisp_write_port.sv
module segdisp_write_port #(
    parameter int DIGITS      = 4,
    parameter int DATA_W      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DIGITS),
    localparam int SEG_W      = segdisp_pkg::SEG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W-1:0]       data_in,
    input  logic [AW-1:0]           addr_in,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    font_code_b,
    output logic [DIGITS*SEG_W-1:0] segs_out
);
    import segdisp_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [AW-1:0]     addr;
        logic              win;
        logic              commit;
    } port_t;

    port_t st_d, st_q;
    logic [1:0] sel_raw_n, sel_s_n;
    logic       win_now;
    glyph_t     glyph;

    assign sel_raw_n = {sel_b_n, sel_a_n};

    for (genvar gs = 0; gs < 2; gs++) begin : g_sync
        segdisp_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_n  (sel_raw_n[gs]),
            .sync_n (sel_s_n[gs])
        );
    end

    assign win_now = (sel_s_n == 2'b00);

    always_comb begin
        st_d        = st_q;
        st_d.win    = win_now;
        st_d.commit = st_q.win && !win_now;
        if (win_now) begin
            st_d.data = data_in;
            st_d.addr = addr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign glyph = glyph_of(4'(st_q.data), font_code_b);

    segdisp_bank #(.DIGITS(DIGITS), .SEG_W(SEG_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_q.commit),
        .wr_addr   (st_q.addr),
        .wr_glyph  (glyph),
        .segs_flat (segs_out)
    );

    // R4: a commit is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.commit |=> !st_q.commit);

    // R2: captured value and address frozen while the window is closed
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !win_now |=> ($stable(st_q.data) && $stable(st_q.addr)));

    // R5: no commit unless the window was open the cycle before
    a_r5_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.win |=> !st_q.commit);
endmodule

// File: tb/segdisp_write_port_test.sv
module segdisp_write_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  data_in = 0;
    logic [1:0]  addr_in = 0;
    logic        sel_a_n = 1, sel_b_n = 1;
    logic        font_code_b = 0;
    logic [27:0] segs_out;

    int total = 0, bad = 0;
    bit done = 0;
    logic [6:0] model [4];

    segdisp_write_port uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .addr_in(addr_in),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .font_code_b(font_code_b),
        .segs_out(segs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // vector: {font, addr[1:0], data[3:0]}
    localparam logic [6:0] VEC [12] = '{
        {1'b0,2'd0,4'd1},  {1'b0,2'd1,4'd2},  {1'b0,2'd2,4'd3},  {1'b0,2'd3,4'd4},
        {1'b0,2'd0,4'd10}, {1'b0,2'd1,4'd11}, {1'b1,2'd2,4'd12}, {1'b1,2'd3,4'd13},
        {1'b1,2'd0,4'd14}, {1'b1,2'd1,4'd15}, {1'b0,2'd2,4'd15}, {1'b0,2'd3,4'd8}
    };

    function automatic logic [6:0] exp_glyph(input logic [3:0] v, input logic cb);
        logic [6:0] hex_t [16];
        logic [6:0] cb_t [6];
        hex_t = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                  7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
        cb_t  = '{7'h40,7'h79,7'h76,7'h38,7'h73,7'h00};
        if (cb && v >= 10) return cb_t[v-10];
        return hex_t[v];
    endfunction

    function automatic logic [27:0] model_flat();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // mode 0: both rise together, 1: A first, 2: B first
    task automatic do_write(input logic [1:0] a, input logic [3:0] d, input logic cb, input int mode);
        @(negedge clk);
        data_in = d; addr_in = a; font_code_b = cb;
        sel_a_n = 0; sel_b_n = 0;
        repeat (3) @(negedge clk);
        if (mode == 0) begin sel_a_n = 1; sel_b_n = 1; end
        else if (mode == 1) begin sel_a_n = 1; @(negedge clk); sel_b_n = 1; end
        else begin sel_b_n = 1; @(negedge clk); sel_a_n = 1; end
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset blank", segs_out, 28'h0);
        rst_n = 1;
        for (int i = 0; i < 4; i++) model[i] = 7'h0;
        @(negedge clk);

        // table walk: R3 R5..R7 R4 across release orders
        for (int i = 0; i < 12; i++) begin
            do_write(VEC[i][5:4], VEC[i][3:0], VEC[i][6], i % 3);
            model[VEC[i][5:4]] = exp_glyph(VEC[i][3:0], VEC[i][6]);
            check("R3/R4/R6/R7 table write", segs_out, model_flat());
        end

        // R9: latency exactly four edges after rise
        @(negedge clk);
        data_in = 4'd7; addr_in = 2'd1; font_code_b = 0;
        sel_a_n = 0; sel_b_n = 0;
        repeat (3) @(negedge clk);
        sel_a_n = 1; sel_b_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 not yet after three edges", segs_out, model_flat());
        @(posedge clk); @(negedge clk);
        model[1] = 7'h07;
        check("R9 visible after four edges", segs_out, model_flat());

        // R2: inputs changed after the hold time are ignored
        repeat (2) @(negedge clk);
        data_in = 4'd2; addr_in = 2'd0;
        repeat (4) @(negedge clk);
        check("R2 late input change ignored", segs_out, model_flat());

        // R5: only one select low never writes
        @(negedge clk);
        sel_a_n = 0; data_in = 4'd9; addr_in = 2'd2;
        repeat (4) @(negedge clk);
        sel_a_n = 1;
        repeat (6) @(negedge clk);
        check("R5 select A alone ignored", segs_out, model_flat());
        sel_b_n = 0;
        repeat (4) @(negedge clk);
        sel_b_n = 1;
        repeat (6) @(negedge clk);
        check("R5 select B alone ignored", segs_out, model_flat());

        // R8: font change after write leaves stored digits alone
        do_write(2'd3, 4'd12, 1'b1, 0);
        model[3] = 7'h76;
        check("R7 code B H", segs_out, model_flat());
        font_code_b = 0;
        repeat (4) @(negedge clk);
        check("R8 later font change ignored", segs_out, model_flat());

        // R4: two back-to-back windows each write once to the right place
        do_write(2'd0, 4'd0, 1'b0, 2);
        do_write(2'd2, 4'd5, 1'b0, 1);
        model[0] = 7'h3F; model[2] = 7'h6D;
        check("R4 consecutive windows", segs_out, model_flat());

        // R1: reset clears written state
        rst_n = 0;
        @(negedge clk);
        check("R1 reset clears digits", segs_out, 28'h0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        check("R1 stays blank with no write", segs_out, 28'h0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule